// File: doc/BRIEF.md
# Token-Bubble Elastic Pipeline

This block is a clocked model of a self-timed linear pipeline. It has `N` stages, and each stage holds either a data token or an empty bubble. On every clock edge each stage makes its own decision, and all stages decide from the state held before the edge. A stage passes its token forward only when it holds a token and its successor holds a bubble. When a token moves forward, the bubble behind it moves one stage backward.

In line mode the first stage takes data through a valid/ready input port, and the last stage presents data through a valid/ready output port. A full pipeline stops accepting input, and an empty one presents nothing at the output. In ring mode the last stage feeds the first, and both external ports are closed. A ring is set up through an initialisation port that preloads a token pattern and its data. The block exports the occupancy of every stage, the number of tokens held, and a pulse that fires each time a token leaves the last stage. With these a user can plot throughput against fill level.

Each stage is a two-state machine:
- `SLOT_BUBBLE` goes to `SLOT_TOKEN` on a fill.
- `SLOT_TOKEN` goes to `SLOT_BUBBLE` on an advance.
- A preload overrides both and forces whichever state the load pattern asks for.

A mode controller has two states, `CTL_LINE` and `CTL_RING`:
- A preload with ring selected takes it to `CTL_RING`.
- A preload with ring cleared takes it back to `CTL_LINE`.
- Otherwise it holds its state.

Top module: `token_bubble_pipe`

## Requirements
- R1: After reset every stage is a bubble (`occ` = 0, `fill_level` = 0), the block is in line mode (`ring_active` = 0), `in_ready` = 1 and `out_valid` = 0.
- R2: In line mode without preload, `in_ready` equals "stage 0 holds a bubble". A word offered with `in_valid` and `in_ready` both high occupies stage 0 after that edge.
- R3: A stage advances its token only if it holds a token and its successor holds a bubble; otherwise it keeps the token and its data. The successor of the last stage is `out_ready` in line mode and stage 0 in ring mode.
- R4: With every stage full and `out_ready` low, `in_ready` is 0, `in_data` is not taken, and `occ` does not change.
- R5: When the last stage holds a bubble, `out_valid` is 0.
- R6: In line mode words leave in the order they were accepted. A word accepted into an empty pipeline is presented at `out_data` with `out_valid` high after `N` clock edges, counting the edge that accepted it.
- R7: All advance decisions use the pre-edge state, so a run of alternating tokens and bubbles moves every token one stage in a single edge.
- R8: A preload (`init_valid`) loads stage i with `init_occ[i]` and data `init_data[i*W +: W]`; with `init_ring` = 1 it enters ring mode. In ring mode `in_ready` and `out_valid` are 0 and `in_valid` has no effect.
- R9: In ring mode the token count never changes. With `N`=4, `tok_exit` fires 4 times in 8 cycles for alternating tokens, 2 times for one token, 2 times for one bubble, and 0 times for a full or an empty ring.
- R10: In ring mode data travels with its token: one token preloaded in stage 0 is in the last stage with its data on `out_data` after `N`-1 edges.
- R11: `fill_level` equals the number of 1 bits in `occ`.
- R12: `tok_exit` is high in a cycle exactly when the last stage advances its token. In line mode this is `out_valid && out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Stage 0 can take a word (line mode) |
| in_data | input | W | Offered word |
| out_valid | output | 1 | Last stage presents a word (line mode) |
| out_ready | input | 1 | Downstream takes the presented word |
| out_data | output | W | Data of the last stage |
| init_valid | input | 1 | Preload the pattern below on this edge |
| init_ring | input | 1 | Preload selects ring mode (1) or line mode (0) |
| init_occ | input | N | Token pattern to preload, bit i for stage i |
| init_data | input | N*W | Data to preload, stage i in bits i*W +: W |
| occ | output | N | Per-stage occupancy, 1 = token |
| fill_level | output | $clog2(N+1) | Number of tokens held |
| tok_exit | output | 1 | A token leaves the last stage in this cycle |
| ring_active | output | 1 | Ring mode is selected |

## Verification
Handshake outputs (`in_ready`, `out_valid`, `tok_exit`) are combinational from the stage registers and ports, so they are due in the same cycle as the state that drives them. Occupancy changes one edge after each advance decision. The bench drives inputs just after the falling edge and samples shortly after, which checks each vector against the pre-edge state. Each expected value in the table then describes the cycle before the next rising edge. The ring tests wait exactly one edge after the preload before they count `tok_exit` over a fixed window. The latency of `N` edges under R6 is read from the row where `out_valid` first rises.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
    typedef enum logic {
        SLOT_BUBBLE = 1'b0,
        SLOT_TOKEN  = 1'b1
    } slot_t;

    typedef enum logic {
        CTL_LINE = 1'b0,
        CTL_RING = 1'b1
    } ctl_t;
endpackage

// File: rtl/tbp_stage.sv
module tbp_stage
    import tbp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         load_tok,
    input  logic [W-1:0] load_val,
    input  logic         take,
    input  logic         give,
    input  logic [W-1:0] din,
    output logic         full,
    output logic [W-1:0] dout
);
    slot_t        cur;
    slot_t        nxt;
    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= SLOT_BUBBLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            SLOT_BUBBLE: begin
                if (load)      nxt = load_tok ? SLOT_TOKEN : SLOT_BUBBLE;
                else if (take) nxt = SLOT_TOKEN;
            end
            SLOT_TOKEN: begin
                if (load)      nxt = load_tok ? SLOT_TOKEN : SLOT_BUBBLE;
                else if (give) nxt = SLOT_BUBBLE;
            end
            default: nxt = SLOT_BUBBLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            val_q <= '0;
        else if (load)                         val_q <= load_val;
        else if (take && cur == SLOT_BUBBLE)   val_q <= din;
    end

    always_comb begin
        full = (cur == SLOT_TOKEN);
        dout = val_q;
    end
endmodule

// File: rtl/tbp_ctl.sv
module tbp_ctl
    import tbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_valid,
    input  logic init_ring,
    output logic ring_active
);
    ctl_t st;
    ctl_t st_n;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CTL_LINE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            CTL_LINE: if (init_valid && init_ring)  st_n = CTL_RING;
            CTL_RING: if (init_valid && !init_ring) st_n = CTL_LINE;
            default:  st_n = CTL_LINE;
        endcase
    end

    always_comb begin
        ring_active = (st == CTL_RING);
    end
endmodule

// File: rtl/tbp_move.sv
module tbp_move #(
    parameter int N = 8
) (
    input  logic [N-1:0] full,
    input  logic         ring,
    input  logic         freeze,
    input  logic         in_valid,
    input  logic         out_ready,
    output logic [N-1:0] give,
    output logic [N-1:0] take
);
    localparam int LAST = N - 1;

    logic [N-1:0] succ_empty;

    for (genvar i = 0; i < LAST; i++) begin : g_succ
        assign succ_empty[i] = ~full[i+1];
    end
    assign succ_empty[LAST] = ring ? ~full[0] : out_ready;

    // consensus: "I hold a token" and "my successor holds a bubble"
    assign give = freeze ? '0 : (full & succ_empty);

    for (genvar i = 1; i < N; i++) begin : g_take
        assign take[i] = give[i-1];
    end
    assign take[0] = freeze ? 1'b0
                   : (ring ? give[LAST] : (in_valid & ~full[0]));
endmodule

// File: rtl/token_bubble_pipe.sv
module token_bubble_pipe #(
    parameter int W = 8,
    parameter int N = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [W-1:0]             in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [W-1:0]             out_data,
    input  logic                     init_valid,
    input  logic                     init_ring,
    input  logic [N-1:0]             init_occ,
    input  logic [N*W-1:0]           init_data,
    output logic [N-1:0]             occ,
    output logic [$clog2(N+1)-1:0]   fill_level,
    output logic                     tok_exit,
    output logic                     ring_active
);
    localparam int LAST = N - 1;
    localparam int CW   = $clog2(N + 1);

    logic [N-1:0] full;
    logic [N-1:0] give;
    logic [N-1:0] take;
    logic [W-1:0] sdata [N];
    logic [W-1:0] sdin  [N];

    tbp_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_valid  (init_valid),
        .init_ring   (init_ring),
        .ring_active (ring_active)
    );

    tbp_move #(.N(N)) u_move (
        .full      (full),
        .ring      (ring_active),
        .freeze    (init_valid),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .give      (give),
        .take      (take)
    );

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign sdin[i] = ring_active ? sdata[LAST] : in_data;
        end else begin : g_body
            assign sdin[i] = sdata[i-1];
        end

        tbp_stage #(.W(W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (init_valid),
            .load_tok (init_occ[i]),
            .load_val (init_data[i*W +: W]),
            .take     (take[i]),
            .give     (give[i]),
            .din      (sdin[i]),
            .full     (full[i]),
            .dout     (sdata[i])
        );
    end

    assign in_ready  = ~full[0] & ~ring_active & ~init_valid;
    assign out_valid = full[LAST] & ~ring_active & ~init_valid;
    assign out_data  = sdata[LAST];
    assign occ       = full;
    assign tok_exit  = give[LAST];

    always_comb begin
        fill_level = '0;
        for (int i = 0; i < N; i++) begin
            fill_level = fill_level + CW'(full[i]);
        end
    end
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
    parameter int W = 8,
    parameter int N = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [W-1:0]           out_data,
    input logic                   init_valid,
    input logic [N-1:0]           occ,
    input logic [$clog2(N+1)-1:0] fill_level,
    input logic                   tok_exit,
    input logic                   ring_active
);
    AST_ENTRY_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> occ[0]); // R2

    AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_active && !init_valid && out_valid && !out_ready)
        |=> (init_valid || (out_valid && $stable(out_data)))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (&occ) |-> !in_ready); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !occ[N-1] |-> !out_valid); // R5

    AST_RING_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ring_active |-> (!in_ready && !out_valid)); // R8

    AST_RING_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_active && !init_valid) |=> (fill_level == $past(fill_level))); // R9

    AST_FILL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level == $countones(occ)); // R11

    AST_EXIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_active |-> (tok_exit == (out_valid && out_ready))); // R12
endmodule

bind token_bubble_pipe tbp_checker #(.W(W), .N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .init_valid  (init_valid),
    .occ         (occ),
    .fill_level  (fill_level),
    .tok_exit    (tok_exit),
    .ring_active (ring_active)
);

// File: tb/token_bubble_pipe_bench.sv
module token_bubble_pipe_bench;
    localparam int W  = 8;
    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [W-1:0] out_data;
    logic init_valid = 1'b0;
    logic init_ring = 1'b0;
    logic [N-1:0] init_occ = '0;
    logic [N*W-1:0] init_data = '0;
    logic [N-1:0] occ;
    logic [CW-1:0] fill_level;
    logic tok_exit;
    logic ring_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    token_bubble_pipe #(.W(W), .N(N)) u_token_bubble_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .init_valid(init_valid), .init_ring(init_ring),
        .init_occ(init_occ), .init_data(init_data),
        .occ(occ), .fill_level(fill_level),
        .tok_exit(tok_exit), .ring_active(ring_active)
    );

    // {in_valid, in_data, out_ready, exp_in_ready, exp_out_valid, exp_out_data, exp_occ}
    localparam logic [23:0] VEC [16] = '{
        {1'b1, 8'hA1, 1'b0, 1'b1, 1'b0, 8'h00, 4'b0000},
        {1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 8'h00, 4'b0001},
        {1'b1, 8'hA2, 1'b0, 1'b1, 1'b0, 8'h00, 4'b0010},
        {1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, 8'h00, 4'b0101},
        {1'b1, 8'hA3, 1'b0, 1'b1, 1'b1, 8'hA1, 4'b1010},
        {1'b1, 8'hA4, 1'b0, 1'b0, 1'b1, 8'hA1, 4'b1101},
        {1'b1, 8'hA4, 1'b0, 1'b1, 1'b1, 8'hA1, 4'b1110},
        {1'b1, 8'hA5, 1'b0, 1'b0, 1'b1, 8'hA1, 4'b1111},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA1, 4'b1111},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'b0111},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA2, 4'b1011},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'b0101},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'hA3, 4'b1010},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 4'b0100},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'hA4, 4'b1000},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 4'b0000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic preload(input bit ring, input logic [N-1:0] pat,
                           input logic [N*W-1:0] vals);
        init_valid = 1'b1;
        init_ring  = ring;
        init_occ   = pat;
        init_data  = vals;
        tick();
        init_valid = 1'b0;
        #1;
    endtask

    task automatic count_exits(input int cycles, output int n);
        n = 0;
        for (int c = 0; c < cycles; c++) begin
            #1;
            if (tok_exit) n++;
            tick();
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state, checked while reset is still held
        check(occ == '0 && fill_level == '0, "R1 occ", 32'(occ), 0);
        check(in_ready && !out_valid && !ring_active, "R1 ports",
              {in_ready, out_valid, ring_active}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R12: line-mode stream table
        for (int v = 0; v < 16; v++) begin
            in_valid  = VEC[v][23];
            in_data   = VEC[v][22:15];
            out_ready = VEC[v][14];
            #1;
            check(occ == VEC[v][3:0], $sformatf("R3 occ row %0d", v), 32'(occ), 32'(VEC[v][3:0]));
            check(in_ready == VEC[v][13], $sformatf("R2 R4 in_ready row %0d", v),
                  32'(in_ready), 32'(VEC[v][13]));
            check(out_valid == VEC[v][12], $sformatf("R5 R6 out_valid row %0d", v),
                  32'(out_valid), 32'(VEC[v][12]));
            if (VEC[v][12])
                check(out_data == VEC[v][11:4], $sformatf("R6 out_data row %0d", v),
                      32'(out_data), 32'(VEC[v][11:4]));
            check(tok_exit == (VEC[v][12] & VEC[v][14]), $sformatf("R12 tok_exit row %0d", v),
                  32'(tok_exit), 32'(VEC[v][12] & VEC[v][14]));
            check(fill_level == CW'($countones(VEC[v][3:0])), $sformatf("R11 fill row %0d", v),
                  32'(fill_level), 32'($countones(VEC[v][3:0])));
            tick();
        end
        in_valid = 1'b0;
        out_ready = 1'b0;

        // R7: alternating tokens all advance on one edge
        preload(1'b0, 4'b0101, {8'h00, 8'hC2, 8'h00, 8'hC0});
        check(occ == 4'b0101, "R8 line preload", 32'(occ), 32'h5);
        tick();
        check(occ == 4'b1010, "R7 all advance", 32'(occ), 32'hA);
        check(out_data == 8'hC2, "R7 data moved", 32'(out_data), 32'hC2);
        tick();
        check(occ == 4'b1100, "R3 last holds, next advances", 32'(occ), 32'hC);

        // R8 R9: alternating ring
        preload(1'b1, 4'b0101, '0);
        check(ring_active && !in_ready && !out_valid, "R8 ring closed",
              {ring_active, in_ready, out_valid}, 3'b100);
        count_exits(8, n);
        check(n == 4, "R9 alternating exits", n, 4);
        check(fill_level == 2, "R9 R11 tokens kept", 32'(fill_level), 2);

        // R9 single token, with input offered and ignored (R8)
        in_valid = 1'b1;
        in_data  = 8'hEE;
        preload(1'b1, 4'b0001, {8'h00, 8'h00, 8'h00, 8'h5A});
        count_exits(8, n);
        check(n == 2, "R9 single token exits", n, 2);
        check(occ == 4'b0001 && fill_level == 1, "R8 input ignored in ring", 32'(occ), 32'h1);
        in_valid = 1'b0;

        // R10 data rides with its token
        preload(1'b1, 4'b0001, {8'h00, 8'h00, 8'h00, 8'h5A});
        tick(); tick(); tick();
        check(occ == 4'b1000, "R10 token at last stage", 32'(occ), 32'h8);
        check(out_data == 8'h5A, "R10 data travelled", 32'(out_data), 32'h5A);

        // R9 one bubble
        preload(1'b1, 4'b1110, '0);
        count_exits(8, n);
        check(n == 2, "R9 single bubble exits", n, 2);

        // R9 full ring moves nothing
        preload(1'b1, 4'b1111, '0);
        count_exits(8, n);
        check(n == 0, "R9 full ring exits", n, 0);
        check(occ == 4'b1111, "R9 full ring frozen", 32'(occ), 32'hF);

        // R9 empty ring moves nothing
        preload(1'b1, 4'b0000, '0);
        count_exits(8, n);
        check(n == 0, "R9 empty ring exits", n, 0);

        // back to line mode
        preload(1'b0, 4'b0000, '0);
        check(!ring_active && in_ready && !out_valid, "R8 line restored",
              {ring_active, in_ready, out_valid}, 3'b010);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule